// File: doc/BRIEF.md
# Traffic test controller

The block sits between a word-oriented register bus and a TCP offload engine. Each bus address is decoded into one of two windows. Addresses in the low window go straight through to the engine's own control registers. Addresses in the second window select a small set of local registers, which control the test and report its status.

Behind those registers are two pieces of test logic. A transmit generator pushes a programmed number of 64-bit words into the engine's transmit FIFO. A receive checker drains the engine's receive FIFO and compares each word with the same counter-derived pattern. Because the generator and the checker use one pattern, two such blocks can be looped back against each other.

The block also latches two events until software clears them. One is any change of the connection-on signal. The other is the engine's timer interrupt.

Top module: `traffic_test_ctrl`

## Requirements
- R1: `reg_addr[15:8]` selects the window.
  - 0x00 is the engine window. A write pulses `eng_wr_en` with `eng_addr = reg_addr[7:2]`, and a read returns `eng_rd_data`.
  - 0x10 is the local window.
  - Any other value, and any unmapped local offset, reads as zero and ignores writes.
- R2: `reg_rd_valid` rises in the cycle after the cycle where `reg_rd_req` is high, and stays high for exactly one cycle per request. `reg_rd_data` is valid in that same cycle. Every write replaces all 32 bits of the target register.
- R3: The local registers at 0x1000 and 0x1010 hold the transfer counts.
  - Writing 0x1000 sets the transmit length in 64-bit words. The write is ignored while a transmit is running.
  - Reading 0x1000 returns the number of words sent.
  - Reading 0x1010 returns the number of words received.
  - Any write to 0x1004 clears both counts.
- R4: The command register at 0x1004 has these fields.
  - Writing bit0=0 starts a transmit, provided the length is nonzero.
  - Writing bit0=1 does not start a transmit, and it stops one that is running.
  - Bit1 of the written value enables data checking.
  - A read returns {bit2 connection-on, bit1 verification error, bit0 transmit busy}.
  - Writing this register clears the error bit.
- R5: The control register at 0x1008 has these fields.
  - Writing bit0=1 resets the generator and checker: it stops the transmit, clears both counts and clears the error bit. Bit0 always reads back as 0.
  - Writing bit8=1 clears the latched timer flag.
  - A read returns bit8 = the latched timer flag and bit16 = `link_up`.
- R6: Reading 0x100C returns `rx_last_cnt` in bits [2:0], `rx_rd_cnt` in bits [15:3] and `tx_full` in bit 24. All other bits read as zero.
- R7: Bit0 of 0x1020 is set by any change of `conn_on`. Writing 1 to that bit clears it, and writing 0 leaves it unchanged. A new change in the same cycle as the clear takes priority.
- R8: While a transmit runs, `tx_wr_en` equals NOT `tx_full`.
  - Word n carries {2n+1, 2n}: the high 32 bits hold 2n+1 and the low 32 bits hold 2n.
  - The transmit stops after the programmed number of words.
- R9: The receive path reads and checks the FIFO as follows.
  - `rx_rd_en` equals NOT `rx_empty`.
  - `rx_data` is sampled one cycle after each read.
  - Each read advances the receive count.
  - When checking is enabled, a word that differs from {2n+1, 2n}, where n is the receive count, sets a sticky error bit.
  - When checking is disabled, mismatches are ignored.
- R10: After hardware reset, the following all read as zero: both counts, the length, the busy flag, the error bit and both event flags. `reg_rd_valid` and `tx_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 16 | Byte address of the register access |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_req | input | 1 | Register read request |
| reg_rd_valid | output | 1 | Read data valid, one cycle after request |
| reg_rd_data | output | 32 | Read data |
| eng_addr | output | 6 | Word address to the engine registers |
| eng_wr_en | output | 1 | Write strobe to the engine registers |
| eng_wr_data | output | 32 | Write data to the engine registers |
| eng_rd_data | input | 32 | Engine register read data, combinational in eng_addr |
| tx_wr_en | output | 1 | Transmit FIFO write enable |
| tx_data | output | 64 | Transmit FIFO write data |
| tx_full | input | 1 | Transmit FIFO full (back-pressure) |
| rx_rd_en | output | 1 | Receive FIFO read enable |
| rx_data | input | 64 | Receive FIFO data, valid one cycle after read |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_rd_cnt | input | 13 | Receive FIFO readable word count |
| rx_last_cnt | input | 3 | Receive FIFO partial-word byte count |
| conn_on | input | 1 | Connection established status |
| timer_irq | input | 1 | Engine timer interrupt |
| link_up | input | 1 | Ethernet link status |

## Verification
The assertions make four assumptions about the surroundings:
- A read request and a write never arrive in the same cycle.
- `conn_on` does not change while reset is held.
- The receive FIFO presents a word only after a read enable.
- The transmit FIFO's full flag is honoured through `tx_wr_en` alone.

The stimulus respects all four. It drives one register transaction at a time on the falling edge, and it holds `conn_on` low during reset. The receive FIFO model only advances on `rx_rd_en`. Transmit lengths are kept small and nonzero, so every run finishes inside the observation window.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
  localparam int CNT_W  = 32;
  localparam int WORD_W = 2 * CNT_W;

  localparam logic [7:0] AREA_ENG = 8'h00;
  localparam logic [7:0] AREA_LOC = 8'h10;

  localparam logic [7:0] OFS_TXLEN = 8'h00;
  localparam logic [7:0] OFS_CMD   = 8'h04;
  localparam logic [7:0] OFS_CTRL  = 8'h08;
  localparam logic [7:0] OFS_FIFO  = 8'h0C;
  localparam logic [7:0] OFS_RXLEN = 8'h10;
  localparam logic [7:0] OFS_CONN  = 8'h20;

  // Word n of the stream: low half 2n, high half 2n+1
  function automatic logic [WORD_W-1:0] patt_word(input logic [CNT_W-1:0] n);
    logic [CNT_W-1:0] lo;
    lo = n << 1;
    return {lo + CNT_W'(1), lo};
  endfunction
endpackage

// File: rtl/ttc_txgen.sv
module ttc_txgen
  import ttc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              halt,
  input  logic              clr,
  input  logic [CNT_W-1:0]  len,
  input  logic              full,
  output logic              wr_en,
  output logic [WORD_W-1:0] data,
  output logic [CNT_W-1:0]  cnt,
  output logic              busy
);
  logic             run;
  logic [CNT_W-1:0] sent;

  assign wr_en = run & ~full;
  assign data  = patt_word(sent);
  assign cnt   = sent;
  assign busy  = run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      sent <= '0;
    end else begin
      if (clr)        sent <= '0;
      else if (wr_en) sent <= sent + CNT_W'(1);

      if (start)                                     run <= 1'b1;
      else if (halt)                                 run <= 1'b0;
      else if (wr_en && (sent + CNT_W'(1) == len))   run <= 1'b0;
    end
  end
endmodule

// File: rtl/ttc_rxchk.sv
module ttc_rxchk
  import ttc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cfg_wr,
  input  logic              cfg_verify,
  input  logic              empty,
  input  logic [WORD_W-1:0] rd_data,
  output logic              rd_en,
  output logic [CNT_W-1:0]  cnt,
  output logic              err
);
  logic rd_q;
  logic verify;

  assign rd_en = ~empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      verify <= 1'b0;
      cnt    <= '0;
      err    <= 1'b0;
    end else begin
      rd_q <= rd_en;
      if (cfg_wr) verify <= cfg_verify;

      if (clr)       cnt <= '0;
      else if (rd_q) cnt <= cnt + CNT_W'(1);

      if (clr)                                             err <= 1'b0;
      else if (rd_q && verify && (rd_data != patt_word(cnt))) err <= 1'b1;
    end
  end
endmodule

// File: rtl/ttc_flag.sv
module ttc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/traffic_test_ctrl.sv
module traffic_test_ctrl
  import ttc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int ENG_AW  = 6,
  parameter int RDCNT_W = 13,
  parameter int LAST_W  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr_en,
  input  logic [CNT_W-1:0]     reg_wr_data,
  input  logic                 reg_rd_req,
  output logic                 reg_rd_valid,
  output logic [CNT_W-1:0]     reg_rd_data,
  output logic [ENG_AW-1:0]    eng_addr,
  output logic                 eng_wr_en,
  output logic [CNT_W-1:0]     eng_wr_data,
  input  logic [CNT_W-1:0]     eng_rd_data,
  output logic                 tx_wr_en,
  output logic [WORD_W-1:0]    tx_data,
  input  logic                 tx_full,
  output logic                 rx_rd_en,
  input  logic [WORD_W-1:0]    rx_data,
  input  logic                 rx_empty,
  input  logic [RDCNT_W-1:0]   rx_rd_cnt,
  input  logic [LAST_W-1:0]    rx_last_cnt,
  input  logic                 conn_on,
  input  logic                 timer_irq,
  input  logic                 link_up
);
  localparam int FF_GAP = 24 - RDCNT_W - LAST_W;

  logic [7:0]       area, ofs;
  logic             hit_eng, hit_loc, loc_wr;
  logic             cmd_wr, soft_rst, tmr_clr, conn_clr, len_wr;
  logic             tx_start, tx_halt, cnt_clr;
  logic [CNT_W-1:0] tx_len, tx_cnt, rx_cnt, loc_rd;
  logic             tx_busy, rx_err, conn_q, conn_edge, conn_flag, tmr_flag;

  // Address decode
  assign area    = reg_addr[15:8];
  assign ofs     = reg_addr[7:0];
  assign hit_eng = (area == AREA_ENG);
  assign hit_loc = (area == AREA_LOC);
  assign loc_wr  = reg_wr_en & hit_loc;

  assign cmd_wr   = loc_wr & (ofs == OFS_CMD);
  assign soft_rst = loc_wr & (ofs == OFS_CTRL) & reg_wr_data[0];
  assign tmr_clr  = loc_wr & (ofs == OFS_CTRL) & reg_wr_data[8];
  assign conn_clr = loc_wr & (ofs == OFS_CONN) & reg_wr_data[0];
  assign len_wr   = loc_wr & (ofs == OFS_TXLEN) & ~tx_busy;

  assign tx_start = cmd_wr & ~reg_wr_data[0] & (tx_len != '0);
  assign tx_halt  = cmd_wr | soft_rst;
  assign cnt_clr  = cmd_wr | soft_rst;

  // Engine window pass-through
  assign eng_addr    = reg_addr[ENG_AW+1:2];
  assign eng_wr_en   = reg_wr_en & hit_eng;
  assign eng_wr_data = reg_wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_len <= '0;
      conn_q <= 1'b0;
    end else begin
      if (len_wr) tx_len <= reg_wr_data;
      conn_q <= conn_on;
    end
  end

  assign conn_edge = conn_on ^ conn_q;

  ttc_txgen u_txgen (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tx_start),
    .halt  (tx_halt),
    .clr   (cnt_clr),
    .len   (tx_len),
    .full  (tx_full),
    .wr_en (tx_wr_en),
    .data  (tx_data),
    .cnt   (tx_cnt),
    .busy  (tx_busy)
  );

  ttc_rxchk u_rxchk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (cnt_clr),
    .cfg_wr     (cmd_wr),
    .cfg_verify (reg_wr_data[1]),
    .empty      (rx_empty),
    .rd_data    (rx_data),
    .rd_en      (rx_rd_en),
    .cnt        (rx_cnt),
    .err        (rx_err)
  );

  ttc_flag u_conn_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (conn_edge),
    .clr   (conn_clr),
    .flag  (conn_flag)
  );

  ttc_flag u_tmr_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (timer_irq),
    .clr   (tmr_clr),
    .flag  (tmr_flag)
  );

  // Local read mux
  always_comb begin
    loc_rd = '0;
    case (ofs)
      OFS_TXLEN: loc_rd = tx_cnt;
      OFS_CMD:   loc_rd = {{(CNT_W-3){1'b0}}, conn_on, rx_err, tx_busy};
      OFS_CTRL:  loc_rd = {15'd0, link_up, 7'd0, tmr_flag, 8'd0};
      OFS_FIFO:  loc_rd = {7'd0, tx_full, {FF_GAP{1'b0}}, rx_rd_cnt, rx_last_cnt};
      OFS_RXLEN: loc_rd = rx_cnt;
      OFS_CONN:  loc_rd = {{(CNT_W-1){1'b0}}, conn_flag};
      default:   loc_rd = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rd_valid <= 1'b0;
      reg_rd_data  <= '0;
    end else begin
      reg_rd_valid <= reg_rd_req;
      if (reg_rd_req)
        reg_rd_data <= hit_eng ? eng_rd_data : (hit_loc ? loc_rd : '0);
    end
  end
endmodule

// File: rtl/ttc_chk.sv
module ttc_chk
  import ttc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_rd_req,
  input logic             reg_rd_valid,
  input logic             tx_full,
  input logic             tx_busy,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] tx_len,
  input logic [CNT_W-1:0] rx_cnt,
  input logic             rx_err,
  input logic             cmd_wr,
  input logic             soft_rst,
  input logic             conn_on,
  input logic             conn_flag,
  input logic             timer_irq,
  input logic             tmr_flag
);
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_req |=> reg_rd_valid); // R2

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (tx_cnt == '0) && (rx_cnt == '0)); // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err && !cmd_wr && !soft_rst) |=> rx_err); // R4

  AST_TMR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    timer_irq |=> tmr_flag); // R5

  AST_CONN_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(conn_on) |=> conn_flag); // R7

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> (tx_cnt < tx_len)); // R8

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && !cmd_wr && !soft_rst) |=> $stable(tx_cnt)); // R8
endmodule

bind traffic_test_ctrl ttc_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_rd_req   (reg_rd_req),
  .reg_rd_valid (reg_rd_valid),
  .tx_full      (tx_full),
  .tx_busy      (tx_busy),
  .tx_cnt       (tx_cnt),
  .tx_len       (tx_len),
  .rx_cnt       (rx_cnt),
  .rx_err       (rx_err),
  .cmd_wr       (cmd_wr),
  .soft_rst     (soft_rst),
  .conn_on      (conn_on),
  .conn_flag    (conn_flag),
  .timer_irq    (timer_irq),
  .tmr_flag     (tmr_flag)
);

// File: tb/traffic_test_ctrl_tb.sv
module traffic_test_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] reg_addr;
  logic        reg_wr_en, reg_rd_req, reg_rd_valid;
  logic [31:0] reg_wr_data, reg_rd_data;
  logic [5:0]  eng_addr;
  logic        eng_wr_en;
  logic [31:0] eng_wr_data, eng_rd_data;
  logic        tx_wr_en, tx_full, rx_rd_en, rx_empty;
  logic [63:0] tx_data, rx_data;
  logic [12:0] rx_rd_cnt;
  logic [2:0]  rx_last_cnt;
  logic        conn_on, timer_irq, link_up;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  traffic_test_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_req(reg_rd_req), .reg_rd_valid(reg_rd_valid),
    .reg_rd_data(reg_rd_data), .eng_addr(eng_addr), .eng_wr_en(eng_wr_en),
    .eng_wr_data(eng_wr_data), .eng_rd_data(eng_rd_data), .tx_wr_en(tx_wr_en),
    .tx_data(tx_data), .tx_full(tx_full), .rx_rd_en(rx_rd_en), .rx_data(rx_data),
    .rx_empty(rx_empty), .rx_rd_cnt(rx_rd_cnt), .rx_last_cnt(rx_last_cnt),
    .conn_on(conn_on), .timer_irq(timer_irq), .link_up(link_up)
  );

  // Engine register model
  logic [31:0] eng_mem [64];
  assign eng_rd_data = eng_mem[eng_addr];
  always @(posedge clk) begin
    if (!rst_n) for (int i = 0; i < 64; i++) eng_mem[i] <= '0;
    else if (eng_wr_en) eng_mem[eng_addr] <= eng_wr_data;
  end

  // Transmit FIFO capture
  logic [63:0] cap [32];
  int cap_n;
  always @(posedge clk) begin
    if (!rst_n) cap_n <= 0;
    else if (tx_wr_en) begin
      if (cap_n < 32) cap[cap_n] <= tx_data;
      cap_n <= cap_n + 1;
    end
  end

  // Receive FIFO model
  logic [63:0] rxq [16];
  int rx_wp, rx_rp;
  assign rx_empty = (rx_rp == rx_wp);
  always @(posedge clk) begin
    if (!rst_n) begin
      rx_rp   <= 0;
      rx_data <= '0;
    end else if (rx_rd_en) begin
      rx_data <= rxq[rx_rp];
      rx_rp   <= rx_rp + 1;
    end
  end

  function automatic logic [63:0] exp_word(input int n);
    return {32'(2 * n + 1), 32'(2 * n)};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a; reg_rd_req = 1'b1;
    @(negedge clk);
    reg_rd_req = 1'b0;
    chk(tag, {32'd0, reg_rd_data}, {32'd0, exp});
  endtask

  task automatic push(input logic [63:0] w);
    @(negedge clk);
    rxq[rx_wp] = w;
    rx_wp++;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {rx_last_cnt, rx_rd_cnt, tx_full, link_up, expected 0x100C, expected 0x1008}
  localparam logic [81:0] VEC [4] = '{
    {3'h5, 13'h0001, 1'b0, 1'b1, 32'h0000000D, 32'h00010000},
    {3'h0, 13'h1FFF, 1'b1, 1'b0, 32'h0100FFF8, 32'h00000000},
    {3'h7, 13'h0000, 1'b1, 1'b1, 32'h01000007, 32'h00010000},
    {3'h2, 13'h0AAA, 1'b0, 1'b0, 32'h00005552, 32'h00000000}
  };

  initial begin
    int base;
    rst_n = 1'b0; reg_addr = '0; reg_wr_en = 1'b0; reg_wr_data = '0; reg_rd_req = 1'b0;
    tx_full = 1'b0; rx_rd_cnt = '0; rx_last_cnt = '0;
    conn_on = 1'b0; timer_irq = 1'b0; link_up = 1'b0; rx_wp = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 rd_valid", {63'd0, reg_rd_valid}, 64'd0);
    chk("R10 tx_wr_en", {63'd0, tx_wr_en}, 64'd0);
    rd_chk(16'h1000, 32'd0, "R10 tx count");
    rd_chk(16'h1004, 32'd0, "R10 cmd status");
    rd_chk(16'h1020, 32'd0, "R10 conn flag");
    @(negedge clk);
    chk("R2 valid drops", {63'd0, reg_rd_valid}, 64'd0);

    // R6 / R5: status vectors
    for (int i = 0; i < 4; i++) begin
      {rx_last_cnt, rx_rd_cnt, tx_full, link_up} = VEC[i][81:64];
      rd_chk(16'h100C, VEC[i][63:32], "R6 fifo status");
      rd_chk(16'h1008, VEC[i][31:0], "R5 link bit");
    end
    tx_full = 1'b0; link_up = 1'b0; rx_rd_cnt = '0; rx_last_cnt = '0;

    // R1 engine window and unmapped space
    wr(16'h0014, 32'hCAFE0001);
    chk("R1 engine write", {32'd0, eng_mem[5]}, 64'hCAFE0001);
    rd_chk(16'h0014, 32'hCAFE0001, "R1 engine read");
    wr(16'h2004, 32'h12345678);
    rd_chk(16'h0004, 32'd0, "R1 unmapped write ignored");
    rd_chk(16'h2004, 32'd0, "R1 unmapped area read");
    rd_chk(16'h1040, 32'd0, "R1 unmapped local read");

    // R8 / R3 plain transmit of 5 words
    base = cap_n;
    wr(16'h1000, 32'd5);
    wr(16'h1004, 32'd0);
    idle(12);
    chk("R8 word count", 64'(cap_n - base), 64'd5);
    for (int i = 0; i < 5; i++) chk("R8 tx pattern", cap[base + i], exp_word(i));
    rd_chk(16'h1000, 32'd5, "R3 sent count");
    rd_chk(16'h1004, 32'd0, "R4 busy clear after end");

    // R8 back-pressure
    tx_full = 1'b1;
    base = cap_n;
    wr(16'h1000, 32'd3);
    wr(16'h1004, 32'd0);
    idle(4);
    chk("R8 no write while full", 64'(cap_n - base), 64'd0);
    rd_chk(16'h1004, 32'd1, "R4 busy while stalled");
    rd_chk(16'h1000, 32'd0, "R3 count cleared by cmd");
    tx_full = 1'b0;
    idle(8);
    chk("R8 resumes after full", 64'(cap_n - base), 64'd3);
    for (int i = 0; i < 3; i++) chk("R8 tx pattern restart", cap[base + i], exp_word(i));

    // R5 soft reset stops transmit
    tx_full = 1'b1;
    base = cap_n;
    wr(16'h1000, 32'd10);
    wr(16'h1004, 32'd0);
    rd_chk(16'h1004, 32'd1, "R4 busy before soft reset");
    wr(16'h1008, 32'd1);
    rd_chk(16'h1004, 32'd0, "R5 soft reset stops");
    rd_chk(16'h1008, 32'd0, "R5 reset bit self-clears");
    tx_full = 1'b0;
    idle(4);
    chk("R5 nothing sent after soft reset", 64'(cap_n - base), 64'd0);

    // R4 bit0=1 does not start
    wr(16'h1004, 32'd1);
    idle(4);
    chk("R4 no start with bit0 set", 64'(cap_n - base), 64'd0);
    rd_chk(16'h1004, 32'd0, "R4 idle with bit0 set");

    // R9 receive with checking, clean data
    wr(16'h1004, 32'd3);
    for (int i = 0; i < 6; i++) push(exp_word(i));
    idle(6);
    rd_chk(16'h1010, 32'd6, "R9 receive count");
    rd_chk(16'h1004, 32'd0, "R9 no error on clean data");

    // R9 mismatch sets sticky error
    wr(16'h1004, 32'd3);
    push(exp_word(0)); push(exp_word(1)); push(exp_word(2) ^ 64'd1); push(exp_word(3));
    idle(6);
    rd_chk(16'h1010, 32'd4, "R9 receive count with error");
    rd_chk(16'h1004, 32'd2, "R9 error flagged");
    push(exp_word(4));
    idle(4);
    rd_chk(16'h1004, 32'd2, "R9 error sticky");
    wr(16'h1004, 32'd3);
    rd_chk(16'h1004, 32'd0, "R4 cmd write clears error");
    rd_chk(16'h1010, 32'd0, "R3 receive count cleared");

    // R9 checking disabled
    wr(16'h1004, 32'd1);
    push(64'hDEAD); push(64'hBEEF);
    idle(5);
    rd_chk(16'h1004, 32'd0, "R9 mismatch ignored when off");
    rd_chk(16'h1010, 32'd2, "R9 count without checking");

    // R5 soft reset clears error
    wr(16'h1004, 32'd3);
    push(64'h1);
    idle(4);
    rd_chk(16'h1004, 32'd2, "R9 error before soft reset");
    wr(16'h1008, 32'd1);
    rd_chk(16'h1004, 32'd0, "R5 soft reset clears error");

    // R5 timer latch
    @(negedge clk); timer_irq = 1'b1;
    @(negedge clk); timer_irq = 1'b0;
    rd_chk(16'h1008, 32'h100, "R5 timer latched");
    wr(16'h1008, 32'h100);
    rd_chk(16'h1008, 32'd0, "R5 timer cleared");

    // R7 connection edge flag
    conn_on = 1'b1;
    idle(2);
    rd_chk(16'h1020, 32'd1, "R7 rising edge");
    rd_chk(16'h1004, 32'd4, "R4 conn status bit");
    wr(16'h1020, 32'd1);
    rd_chk(16'h1020, 32'd0, "R7 write one clears");
    conn_on = 1'b0;
    idle(2);
    rd_chk(16'h1020, 32'd1, "R7 falling edge");
    wr(16'h1020, 32'd0);
    rd_chk(16'h1020, 32'd1, "R7 write zero keeps");
    wr(16'h1020, 32'd1);
    rd_chk(16'h1020, 32'd0, "R7 cleared again");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule